// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces the clock for a smart card contact. It divides a reference clock by 1, 2, 4 or 8. Two select inputs choose the ratio, and the ratio may change at any moment while the output runs. A single enable from the activation sequencer starts and stops the output. Whenever the output is stopped it rests low.

The block runs from a tick clock, `clk_tick`, at twice the reference frequency. Each half period of the card clock is therefore a whole number of ticks: `HALF_TICKS` ticks per reference half period, multiplied by the ratio. A new ratio is taken only at a rising edge of the output, so every pulse has its high phase and its following low phase at one ratio. The pulses just before and just after a change therefore keep their full width. The enable has the same restriction. The output can rise only after a complete low phase, and once high it always finishes its high phase. Select and enable pass through one register stage before use.

Top module: `card_clk_div`

## Requirements
- R1: While `rst_n` is low, and after reset for as long as `clk_en` stays low, `card_clk` is low.
- R2: A ratio is selected by `div_sel` as follows: 2'b00 divides by 8, 2'b01 by 4, 2'b11 by 2 and 2'b10 by 1. Every high phase of `card_clk` lasts ratio × `HALF_TICKS` ticks of `clk_tick`.
- R3: With a steady `div_sel` and `clk_en` high, the low phase equals the preceding high phase, giving a 50% duty cycle.
- R4: A new ratio takes effect only at a rising edge of `card_clk`. Each low phase therefore lasts at least as long as the high phase before it, and the output matches a behavioural cycle model on every tick.
- R5: Across any sequence of ratio changes, no high or low phase is shorter than `HALF_TICKS` ticks, which is half the shortest period.
- R6: `card_clk` rises only if `clk_en` was high two `clk_tick` edges earlier, and the first pulse after a start has full width.
- R7: When `clk_en` falls during a high phase, the high phase completes at full length and `card_clk` then stays low.
- R8: From a stopped, idle output, `card_clk` is high after the second rising `clk_tick` edge that follows `clk_en` going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tick | input | 1 | Tick clock, twice the reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio select (encoding in R2) |
| clk_en | input | 1 | Run request from the sequencer |
| card_clk | output | 1 | Divided clock to the card, low when stopped |

## Verification
Several properties are checked on every tick. Each phase must last at least the minimum half period, and each high phase must have a legal length. A low phase must never be shorter than the high phase before it. A rise must always follow an enable that was high two edges earlier. Other behaviour can only be shown by the bench's scenarios, which compare the output against a behavioural model on every tick. These include the exact length of each ratio in the encoding, the two-edge start latency, the full-width first and last pulses at a start or stop, and the absence of runt phases under hundreds of random ratio and enable changes.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;
  localparam int unsigned MAX_RATIO = 8;

  // Map the select code to a division ratio.
  function automatic int unsigned ratio_of(input logic [1:0] code);
    case (code)
      2'b00:   ratio_of = 8;
      2'b01:   ratio_of = 4;
      2'b11:   ratio_of = 2;
      default: ratio_of = 1;
    endcase
  endfunction
endpackage

// File: rtl/cdiv_sample.sv
module cdiv_sample #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen #(
  parameter int HALF_TICKS = 1,
  parameter int HALF_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic [HALF_W-1:0] half_req,
  output logic              clk_out,
  output logic              phase_end,
  output logic              ratio_load
);
  logic [HALF_W-1:0] cur_half;
  logic [HALF_W-1:0] cnt;

  // The current phase has lasted its full length (saturates when idle low).
  assign phase_end  = (cnt >= cur_half - 1'b1);
  // A new pulse starts only from a complete low phase with run requested.
  assign ratio_load = !clk_out && phase_end && run_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_out  <= 1'b0;
      cnt      <= '0;
      cur_half <= HALF_W'(HALF_TICKS);
    end else if (!clk_out) begin
      if (ratio_load) begin
        clk_out  <= 1'b1;
        cnt      <= '0;
        cur_half <= half_req;
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (phase_end) begin
        clk_out <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int HALF_TICKS = 1
) (
  input  logic       clk_tick,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       clk_en,
  output logic       card_clk
);
  import card_clk_div_pkg::*;

  localparam int HALF_W = $clog2(MAX_RATIO * HALF_TICKS + 1);

  logic [2:0]        in_q;
  logic [1:0]        sel_q;
  logic              en_q;
  logic [HALF_W-1:0] half_req;
  logic              phase_end;
  logic              ratio_load;

  cdiv_sample #(.WIDTH(3)) u_sample (
    .clk   (clk_tick),
    .rst_n (rst_n),
    .d     ({clk_en, div_sel}),
    .q     (in_q)
  );

  assign sel_q    = in_q[1:0];
  assign en_q     = in_q[2];
  assign half_req = HALF_W'(ratio_of(sel_q) * HALF_TICKS);

  cdiv_phase_gen #(.HALF_TICKS(HALF_TICKS), .HALF_W(HALF_W)) u_phase (
    .clk        (clk_tick),
    .rst_n      (rst_n),
    .run_req    (en_q),
    .half_req   (half_req),
    .clk_out    (card_clk),
    .phase_end  (phase_end),
    .ratio_load (ratio_load)
  );
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int HALF_TICKS = 1
) (
  input logic clk_tick,
  input logic rst_n,
  input logic clk_en,
  input logic card_clk,
  input logic phase_end,
  input logic ratio_load
);
  localparam int RUN_W = $clog2(8 * HALF_TICKS + 1) + 2;
  localparam logic [RUN_W-1:0] L1 = RUN_W'(HALF_TICKS);
  localparam logic [RUN_W-1:0] L2 = RUN_W'(2 * HALF_TICKS);
  localparam logic [RUN_W-1:0] L4 = RUN_W'(4 * HALF_TICKS);
  localparam logic [RUN_W-1:0] L8 = RUN_W'(8 * HALF_TICKS);

  logic             prev;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] hi_len;
  logic             edge_seen;

  assign edge_seen = (card_clk != prev);

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      run    <= '0;
      hi_len <= '0;
    end else begin
      prev <= card_clk;
      if (edge_seen) begin
        run <= RUN_W'(1);
        if (prev) hi_len <= run;
      end else if (run != '1) begin
        run <= run + 1'b1;
      end
    end
  end

  always @(posedge clk_tick) begin
    if (!rst_n) AST_RESET_LOW: assert (card_clk == 1'b0); // R1
  end

  AST_MIN_PHASE: assert property (@(posedge clk_tick) disable iff (!rst_n)
    edge_seen |-> run >= L1); // R5

  AST_HIGH_LEGAL: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (edge_seen && prev) |-> (run == L1 || run == L2 || run == L4 || run == L8)); // R2

  AST_LOW_COVERS_HIGH: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (edge_seen && !prev) |-> run >= hi_len); // R4

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk_tick) disable iff (!rst_n)
    $rose(card_clk) |-> $past(clk_en, 2)); // R6

  AST_LOAD_RISES: assert property (@(posedge clk_tick) disable iff (!rst_n)
    ratio_load |=> card_clk); // R4

  AST_HIGH_ENDS: assert property (@(posedge clk_tick) disable iff (!rst_n)
    (card_clk && phase_end) |=> !card_clk); // R7
endmodule

bind card_clk_div card_clk_div_chk #(.HALF_TICKS(HALF_TICKS)) u_chk (
  .clk_tick   (clk_tick),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .card_clk   (card_clk),
  .phase_end  (phase_end),
  .ratio_load (ratio_load)
);

// File: tb/card_clk_div_tb.sv
module card_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HT = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       clk_en = 1'b0;
  logic       card_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_clk_div #(.HALF_TICKS(HT)) dut_i (
    .clk_tick (clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .clk_en   (clk_en),
    .card_clk (card_clk)
  );

  function automatic int divisor(input logic [1:0] c);
    if (c == 2'b00) return 8;
    if (c == 2'b01) return 4;
    if (c == 2'b11) return 2;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a countdown of ticks left in the current phase,
  // with the inputs seen one edge late.
  int   m_left, m_len;
  bit   m_out, m_en_d;
  logic [1:0] m_sel_d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_left = HT - 1; m_len = HT; m_en_d = 0; m_sel_d = 2'b00;
    end else begin
      if (!m_out) begin
        if (m_left <= 0 && m_en_d) begin
          m_len = divisor(m_sel_d) * HT;
          m_out = 1; m_left = m_len - 1;
        end else if (m_left > 0) m_left--;
      end else if (m_left == 0) begin
        m_out = 0; m_left = m_len - 1;
      end else m_left--;
      m_en_d = clk_en; m_sel_d = div_sel;
    end
  end

  // Tick-by-tick model comparison and phase-width monitor.
  int run = 0, last_hi = 0;
  bit prev = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(card_clk === m_out, "R4 model", card_clk, m_out);
      if (card_clk !== prev) begin
        check(run >= HT, "R5 min phase", run, HT);
        if (prev) begin
          check(run == HT || run == 2*HT || run == 4*HT || run == 8*HT, "R2 high len", run, HT);
          last_hi = run;
        end else begin
          check(run >= last_hi, "R4 low covers high", run, last_hi);
        end
        run = 1;
      end else run++;
      prev = card_clk;
    end
  end

  task automatic measure(output int hi, output int lo);
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    hi = 0; while (card_clk === 1'b1) begin hi++; @(negedge clk); end
    lo = 0; while (card_clk === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    finish_run();
  end

  initial begin
    int hi, lo, seen;
    // R1: low in reset and while disabled afterwards
    repeat (3) @(negedge clk);
    check(card_clk === 1'b0, "R1 in reset", card_clk, 0);
    rst_n = 1'b1;
    seen = 0;
    repeat (20) begin @(negedge clk); if (card_clk !== 1'b0) seen++; end
    check(seen == 0, "R1 idle after reset", seen, 0);

    // R8: start latency of two edges
    div_sel = 2'b01; clk_en = 1'b1;
    @(negedge clk);
    check(card_clk === 1'b0, "R8 one edge", card_clk, 0);
    @(negedge clk);
    check(card_clk === 1'b1, "R8 two edges", card_clk, 1);

    // R2 and R3: each select code, steady
    for (int c = 0; c < 4; c++) begin
      div_sel = 2'(c);
      repeat (40) @(negedge clk);
      measure(hi, lo);
      check(hi == divisor(2'(c)) * HT, "R2 high length", hi, divisor(2'(c)) * HT);
      check(lo == hi, "R3 duty", lo, hi);
    end

    // R7: stop during a high phase
    div_sel = 2'b00;
    repeat (40) @(negedge clk);
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    clk_en = 1'b0;
    hi = 0; while (card_clk === 1'b1) begin hi++; @(negedge clk); end
    check(hi == 8 * HT, "R7 last pulse full", hi, 8 * HT);
    seen = 0;
    repeat (40) begin @(negedge clk); if (card_clk !== 1'b0) seen++; end
    check(seen == 0, "R7 held low", seen, 0);

    // R6: first pulse after restart is full width
    div_sel = 2'b01; clk_en = 1'b1;
    while (card_clk !== 1'b1) @(negedge clk);
    hi = 0; while (card_clk === 1'b1) begin hi++; @(negedge clk); end
    lo = 0; while (card_clk === 1'b0) begin lo++; @(negedge clk); end
    check(hi == 4 * HT, "R6 first high full", hi, 4 * HT);
    check(lo == 4 * HT, "R6 first low full", lo, 4 * HT);

    // R4 and R5: random ratio and enable changes
    for (int i = 0; i < 400; i++) begin
      div_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) clk_en = ~clk_en;
      repeat ($urandom_range(1, 20)) @(negedge clk);
    end
    clk_en = 1'b1;
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule